// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port seen by software through a small register bus. Each pin can be an input or an output. A direction register chooses which, an output latch holds the value to drive, an analog-select register marks pins handed over to analog use, and a per-pin pull-up enable works together with one global pull-up disable bit. On the pad side every pin has an output value, an output enable, a weak pull-up request and a raw input. The raw input passes through a two-stage synchronizer before software can read it.

Reset puts every pin in input mode with the latch cleared and all pull-ups off. A configuration strap, sampled while reset is held, decides whether the low pins come up analog or digital. The upper pins always come up digital. The register map is word-per-register: PORT at 0, LATCH at 1, DIR at 2, ANSEL at 3, PUEN at 4 and CTRL at 5, where CTRL bit 0 is the global pull-up disable. Addresses 6 and 7 are unmapped.

Top module: `gpio_port`

## Requirements
- R1: A DIR bit of 1 makes that pin an input, with `pad_oe` low. A DIR bit of 0 raises `pad_oe`. A write to DIR (address 2) is visible on `pad_oe` after the next rising clock edge.
- R2: `pad_out` always carries the output latch. A write to LATCH (address 1) shows on `pad_out` after the next rising clock edge.
- R3: Reading LATCH returns the latched value and not the pin level.
- R4: A write to PORT (address 0) updates the output latch in the same way as a write to LATCH.
- R5: `pad_pu` for a pin is high only when all three of these hold: its PUEN bit (address 4) is 1, CTRL bit 0 (address 5) is 0, and its DIR bit is 1.
- R6: After reset, LATCH reads 0x00, DIR reads 0xFF, PUEN reads 0x00 and CTRL reads 0x01. As a result `pad_oe` and `pad_pu` are all zero.
- R7: If `cfg_strap` is 0 during reset, ANSEL (address 3) comes up as 0x3F, which puts pins 5..0 in analog mode. If `cfg_strap` is 1, ANSEL comes up as 0x00. Pins 7..6 are digital either way.
- R8: Reading PORT returns the synchronized pin input, with every pin whose ANSEL bit is 1 forced to 0. An analog pin with DIR 0 still drives its latch value out.
- R9: A change on `pad_in` is not seen through PORT after one rising edge. It is seen after the second rising edge.
- R10: Reads of addresses 6 and 7 return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_strap | input | 1 | Reset-time selector: 1 makes the low pins digital |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Value driven to each pin |
| pad_oe | output | 8 | Output driver enable for each pin |
| pad_pu | output | 8 | Weak pull-up request for each pin |

## Verification
The hardest case to reach is the three-way condition for a pull-up. The per-pin enable, the global disable and the direction can each block it on their own, so the pull-up shows only when all three agree. The stimulus sweeps every value of PUEN against both settings of the global bit and against several direction patterns, so that each gate is seen blocking by itself. The strap-dependent reset value can only be observed by resetting a second time with the strap flipped, so the bench does that.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PORT  = 3'd0,
        SEL_LATCH = 3'd1,
        SEL_DIR   = 3'd2,
        SEL_ANSEL = 3'd3,
        SEL_PUEN  = 3'd4,
        SEL_CTRL  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W        = 8,
    parameter int ANA_PINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_strap,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      ansel_q,
    output logic [W-1:0]      puen_q,
    output logic              pu_off_q
);
    localparam logic [W-1:0] ANA_MASK = W'((1 << ANA_PINS) - 1);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q    <= '0;
            dir_q    <= '1;
            ansel_q  <= cfg_strap ? '0 : ANA_MASK;
            puen_q   <= '0;
            pu_off_q <= 1'b1;
        end else if (bus_wr) begin
            case (sel)
                SEL_PORT,
                SEL_LATCH: lat_q    <= bus_wdata;
                SEL_DIR:   dir_q    <= bus_wdata;
                SEL_ANSEL: ansel_q  <= bus_wdata;
                SEL_PUEN:  puen_q   <= bus_wdata;
                SEL_CTRL:  pu_off_q <= bus_wdata[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int W = 8
) (
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ansel_q,
    input  logic [W-1:0] puen_q,
    input  logic         pu_off_q,
    input  logic [W-1:0] sync_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] port_val
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        assign pad_out[p]  = lat_q[p];
        assign pad_oe[p]   = ~dir_q[p];
        assign pad_pu[p]   = puen_q[p] & ~pu_off_q & dir_q[p];
        assign port_val[p] = sync_in[p] & ~ansel_q[p];
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W        = 8,
    parameter int ANA_PINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_strap,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu
);
    logic [W-1:0] lat_q, dir_q, ansel_q, puen_q, sync_in, port_val;
    logic         pu_off_q;

    gpio_regs #(.W(W), .ANA_PINS(ANA_PINS)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .lat_q(lat_q), .dir_q(dir_q), .ansel_q(ansel_q),
        .puen_q(puen_q), .pu_off_q(pu_off_q)
    );

    gpio_sync #(.W(W), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(sync_in)
    );

    gpio_pad #(.W(W)) pad_i (
        .lat_q(lat_q), .dir_q(dir_q), .ansel_q(ansel_q), .puen_q(puen_q),
        .pu_off_q(pu_off_q), .sync_in(sync_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .port_val(port_val)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_PORT:  bus_rdata = port_val;
            SEL_LATCH: bus_rdata = lat_q;
            SEL_DIR:   bus_rdata = dir_q;
            SEL_ANSEL: bus_rdata = ansel_q;
            SEL_PUEN:  bus_rdata = puen_q;
            SEL_CTRL:  bus_rdata = {{(W-1){1'b0}}, pu_off_q};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] ansel_q
);
    a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> pad_oe == ~$past(bus_wdata));

    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> pad_out == $past(bus_wdata));

    a_r4_port_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> pad_out == $past(bus_wdata));

    a_r3_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd1) |-> bus_rdata == pad_out);

    a_r5_pu_never_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_pu == '0 && pad_oe == '0 && pad_out == '0));

    a_r8_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> (bus_rdata & ansel_q) == '0);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 3'd5) |-> bus_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .ansel_q(ansel_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_strap = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; cfg_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R6 / R7 reset state, strap 0
        do_reset(1'b0);
        rd(3'd1, v); chk("R6 latch", v, 8'h00);
        rd(3'd2, v); chk("R6 dir", v, 8'hFF);
        rd(3'd4, v); chk("R6 puen", v, 8'h00);
        rd(3'd5, v); chk("R6 ctrl", v, 8'h01);
        chk("R6 pad_oe", pad_oe, 8'h00);
        chk("R6 pad_pu", pad_pu, 8'h00);
        rd(3'd3, v); chk("R7 ansel strap0", v, 8'h3F);

        // R1 / R2 / R3 sweep of direction against a latch pattern
        for (int d = 0; d < 256; d++) begin
            wr(3'd1, 8'(d ^ 8'hA5));
            wr(3'd2, 8'(d));
            #1;
            chk("R1 pad_oe", pad_oe, ~8'(d));
            chk("R2 pad_out", pad_out, 8'(d ^ 8'hA5));
            rd(3'd1, v); chk("R3 latch read", v, 8'(d ^ 8'hA5));
        end

        // R3 latch readback differs from pin level
        wr(3'd3, 8'h00); wr(3'd2, 8'hFF); wr(3'd1, 8'hA5);
        pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        rd(3'd1, v); chk("R3 latch not pin", v, 8'hA5);
        rd(3'd0, v); chk("R8 port reads pin", v, 8'h5A);

        // R4 port write updates latch
        wr(3'd0, 8'hC3);
        rd(3'd1, v); chk("R4 port write latch", v, 8'hC3);
        chk("R4 pad_out", pad_out, 8'hC3);

        // R5 pull-up sweep
        for (int g = 0; g < 2; g++) begin
            wr(3'd5, 8'(g));
            for (int k = 0; k < 3; k++) begin
                logic [7:0] dv;
                dv = (k == 0) ? 8'hFF : (k == 1) ? 8'h0F : 8'h96;
                wr(3'd2, dv);
                for (int p = 0; p < 256; p++) begin
                    wr(3'd4, 8'(p));
                    #1;
                    chk("R5 pad_pu", pad_pu, (g == 1) ? 8'h00 : (8'(p) & dv));
                end
            end
        end

        // R8 analog masking sweep with all pins high
        wr(3'd2, 8'hFF);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            wr(3'd3, 8'(a));
            rd(3'd0, v); chk("R8 analog masked", v, ~8'(a));
        end
        // R8 analog pins still drive outputs
        wr(3'd3, 8'hFF); wr(3'd2, 8'h00); wr(3'd1, 8'h3C);
        #1;
        chk("R8 analog drive oe", pad_oe, 8'hFF);
        chk("R8 analog drive out", pad_out, 8'h3C);

        // R9 two-edge input latency
        wr(3'd3, 8'h00);
        @(negedge clk);
        pad_in = 8'h81;
        bus_addr = 3'd0;
        @(negedge clk); #1;
        chk("R9 one edge old", bus_rdata, 8'hFF);
        @(negedge clk); #1;
        chk("R9 two edges new", bus_rdata, 8'h81);

        // R10 unmapped addresses
        wr(3'd6, 8'h55); wr(3'd7, 8'hAA);
        rd(3'd6, v); chk("R10 read 6", v, 8'h00);
        rd(3'd7, v); chk("R10 read 7", v, 8'h00);
        rd(3'd1, v); chk("R10 latch kept", v, 8'h3C);
        rd(3'd2, v); chk("R10 dir kept", v, 8'h00);
        rd(3'd3, v); chk("R10 ansel kept", v, 8'h00);
        rd(3'd4, v); chk("R10 puen kept", v, 8'hFF);
        rd(3'd5, v); chk("R10 ctrl kept", v, 8'h01);

        // R7 strap 1 reset
        do_reset(1'b1);
        rd(3'd3, v); chk("R7 ansel strap1", v, 8'h00);
        rd(3'd2, v); chk("R6 dir after 2nd reset", v, 8'hFF);
        chk("R6 pad_pu after 2nd reset", pad_pu, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule